// File: doc/BRIEF.md
# Card Response Turnaround Timer

This block sets when an emulated vicinity card may begin its answer to a reader request. It counts cycles of the 13.56 MHz carrier through a clock-enable input. Counting starts at the synchronization edge that marks the reader's end of frame. From that edge the block opens a permitted start window. If the response data arrives early, the transmit-start pulse is held back until the lower bound of the window. If the data is still missing at the upper bound, the block raises a miss pulse and sends nothing.

Read and inventory commands use a narrow window of 4320 to 4384 carrier cycles. Write commands with the hold flag clear use a separate, much longer window. Write commands with the hold flag set wait for a further reader end-of-frame edge. From that edge the block applies the narrow window. After the card's own end of frame, the block stays busy for the reader's minimum quiet gap of 4192 carrier cycles.

Frame decoding and encoding sit outside this block. The block only turns edges and levels into one start decision per request.

Top module: `card_turnaround_timer`

## Requirements
- R1: After reset, tx_start, win_miss and busy are all 0.
- R2: For a non-write command (cmd_write=0) with rsp_ready already high, tx_start pulses on exactly carrier tick 4320 counted from the rdr_sync edge, and not earlier.
- R3: If rsp_ready first holds at a tick t with 4320 <= t <= 4384 of a read window, tx_start pulses on tick t.
- R4: If rsp_ready is still low at tick 4384 of a read window, win_miss pulses on that tick, tx_start does not pulse, and busy returns to 0.
- R5: A write command (cmd_write=1) with opt_flag=0 uses the window WR_MIN_CYC (default 4352) to WR_MAX_CYC (default 271200, 20 ms), under the same early-ready and miss rules.
- R6: A write command with opt_flag=1 issues no tx_start and keeps busy high until a rdr_resume pulse. From that pulse it applies the read window of 4320 to 4384 ticks.
- R7: A rdr_sync pulse during an open window restarts the count at zero and discards the pending response. The new window takes the command type sampled with that pulse.
- R8: busy is high from the rdr_sync edge until the response is sent. After a card_eof pulse it stays high for exactly 4192 further carrier ticks and drops on tick 4192.
- R9: tx_start and win_miss are one-cycle pulses and are never high together. opt_flag has no effect when cmd_write=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_en | input | 1 | One-cycle enable per 13.56 MHz carrier cycle |
| rdr_sync | input | 1 | Pulse at the rising edge of the reader end of frame |
| cmd_write | input | 1 | Command is a write, sampled with rdr_sync |
| opt_flag | input | 1 | Write hold flag, sampled with rdr_sync |
| rdr_resume | input | 1 | Pulse at a later reader end-of-frame edge that releases a held write |
| rsp_ready | input | 1 | Response data is available |
| card_eof | input | 1 | Pulse when the card's own frame ends |
| tx_start | output | 1 | One-cycle pulse: begin transmitting the response |
| win_miss | output | 1 | One-cycle pulse: window closed without a response |
| busy | output | 1 | A turnaround, response or reader gap is in progress |

## Verification
Ready times are varied against each window. Data that is ready long before the lower bound checks the hold-back. Data that becomes ready inside the window checks the start on that exact tick. Data that arrives at or past the upper bound separates a late start from a miss. The carrier enable is gapped at random, so the counter is shown to follow carrier ticks rather than clock cycles. Directed runs set the hold flag on reads and on writes, issue a mid-window re-sync, and time the post-response gap, which separates the three window kinds and the restart path.

// File: rtl/card_turnaround_timer.sv
module card_turnaround_timer #(
  parameter int RD_MIN_CYC = 4320,
  parameter int RD_MAX_CYC = 4384,
  parameter int WR_MIN_CYC = 4352,
  parameter int WR_MAX_CYC = 271200,
  parameter int GAP_CYC    = 4192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_en,
  input  logic rdr_sync,
  input  logic cmd_write,
  input  logic opt_flag,
  input  logic rdr_resume,
  input  logic rsp_ready,
  input  logic card_eof,
  output logic tx_start,
  output logic win_miss,
  output logic busy
);
  localparam int TOP = (WR_MAX_CYC > RD_MAX_CYC) ? WR_MAX_CYC : RD_MAX_CYC;
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] RD_LO = CW'(RD_MIN_CYC);
  localparam logic [CW-1:0] RD_HI = CW'(RD_MAX_CYC);
  localparam logic [CW-1:0] WR_LO = CW'(WR_MIN_CYC);
  localparam logic [CW-1:0] WR_HI = CW'(WR_MAX_CYC);
  localparam logic [CW-1:0] GAP   = CW'(GAP_CYC);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_WIN, S_TX, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_win;

  wire [CW-1:0] nxt = cnt + 1'b1;
  wire [CW-1:0] lo  = wr_win ? WR_LO : RD_LO;
  wire [CW-1:0] hi  = wr_win ? WR_HI : RD_HI;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wr_win   <= 1'b0;
      tx_start <= 1'b0;
      win_miss <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      win_miss <= 1'b0;
      if (rdr_sync) begin
        cnt    <= '0;
        wr_win <= cmd_write & ~opt_flag;
        st     <= (cmd_write & opt_flag) ? S_HOLD : S_WIN;
      end else begin
        case (st)
          S_HOLD: if (rdr_resume) begin
            cnt    <= '0;
            wr_win <= 1'b0;
            st     <= S_WIN;
          end
          S_WIN: if (carrier_en) begin
            cnt <= nxt;
            if (rsp_ready && nxt >= lo) begin
              tx_start <= 1'b1;
              st       <= S_TX;
            end else if (nxt >= hi) begin
              win_miss <= 1'b1;
              st       <= S_IDLE;
            end
          end
          S_TX: if (card_eof) begin
            cnt <= '0;
            st  <= S_GAP;
          end
          S_GAP: if (carrier_en) begin
            cnt <= nxt;
            if (nxt >= GAP) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module card_turnaround_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rdr_sync,
  input logic tx_start,
  input logic win_miss,
  input logic busy
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && win_miss));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> busy);
  p_miss_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_miss |-> !busy);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_sync |=> (!tx_start && !win_miss));
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rdr_sync) |=> !tx_start);
endmodule

bind card_turnaround_timer card_turnaround_timer_chk u_chk (.*);

// File: tb/card_turnaround_timer_tb.sv
`timescale 1ns/1ps
module card_turnaround_timer_tb;
  localparam int RLO = 4320, RHI = 4384, WLO = 4352, WHI = 6000, GAPC = 4192;

  logic clk = 0, rst_n = 0, carrier_en = 0, rdr_sync = 0, cmd_write = 0;
  logic opt_flag = 0, rdr_resume = 0, rsp_ready = 0, card_eof = 0;
  logic tx_start, win_miss, busy;
  int checks = 0, fails = 0, tb_cnt = 0, cycles = 0;

  always #4 clk = ~clk;

  card_turnaround_timer #(.WR_MAX_CYC(WHI)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tick(input int ready_at, input int lo, input int hi);
    if (ready_at > hi) return -1;
    return (ready_at > lo) ? ready_at : lo;
  endfunction

  task automatic step(input bit rdy);
    carrier_en = ($urandom % 8) != 0;
    rsp_ready  = rdy;
    @(posedge clk);
    if (carrier_en) tb_cnt++;
    @(negedge clk);
  endtask

  task automatic fire_sync(input bit wr, input bit opt);
    rdr_sync = 1; cmd_write = wr; opt_flag = opt; carrier_en = 1;
    @(posedge clk); @(negedge clk);
    rdr_sync = 0; cmd_write = $urandom; opt_flag = $urandom; tb_cnt = 0;
  endtask

  task automatic watch(input int ready_at, input int lo, input int hi, input string req);
    int e = exp_tick(ready_at, lo, hi);
    forever begin
      step(tb_cnt >= ready_at - 1);
      if (tx_start || win_miss || tb_cnt > hi + 2) break;
    end
    if (e >= 0) chk(tx_start && !win_miss && tb_cnt == e, req, tx_start ? tb_cnt : -1, e);
    else chk(win_miss && !tx_start && !busy && tb_cnt == hi, req, win_miss ? tb_cnt : -1, hi);
    rsp_ready = 0;
    step(0);
    chk(!tx_start && !win_miss, "R9 pulse width", tx_start + win_miss, 0);
  endtask

  task automatic finish_rsp();
    card_eof = 1; @(posedge clk); @(negedge clk); card_eof = 0; tb_cnt = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected done", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    bit hit;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!tx_start && !win_miss && !busy, "R1 reset", {tx_start, win_miss, busy}, 0);

    fire_sync(0, 0);
    chk(busy, "R8 busy after sync", busy, 1);
    watch(1, RLO, RHI, "R2 early ready held to min");
    fire_sync(0, 0); watch(4350, RLO, RHI, "R3 ready inside window");
    fire_sync(0, 0); watch(RHI, RLO, RHI, "R3 ready at last tick");
    fire_sync(0, 0); watch(RHI + 1, RLO, RHI, "R4 late ready misses");
    fire_sync(0, 1); watch(1, RLO, RHI, "R9 opt_flag ignored on read");
    fire_sync(1, 0); watch(1, WLO, WHI, "R5 write min bound");
    fire_sync(1, 0); watch(WHI + 5, WLO, WHI, "R5 write max bound miss");

    fire_sync(1, 1);
    hit = 0;
    while (tb_cnt < WHI + 10) begin step(1); if (tx_start || win_miss) hit = 1; end
    chk(!hit && busy, "R6 held write waits", hit, 0);
    rdr_resume = 1; @(posedge clk); @(negedge clk); rdr_resume = 0; tb_cnt = 0;
    watch(1, RLO, RHI, "R6 window from resume edge");

    fire_sync(0, 0);
    hit = 0;
    while (tb_cnt < 4330) begin step(0); if (tx_start || win_miss) hit = 1; end
    chk(!hit, "R7 no output before restart", hit, 0);
    fire_sync(0, 0); watch(1, RLO, RHI, "R7 restart from new sync");

    fire_sync(0, 0); watch(2, RLO, RHI, "R2 start before gap");
    repeat (5) step(0);
    chk(busy, "R8 busy until card eof", busy, 1);
    finish_rsp();
    hit = 0;
    forever begin
      step(0);
      if (tb_cnt < GAPC && !busy) hit = 1;
      if (!busy || tb_cnt > GAPC + 2) break;
    end
    chk(!hit && tb_cnt == GAPC, "R8 gap length", tb_cnt, GAPC);

    for (int i = 0; i < 8; i++) begin
      bit wr = $urandom;
      int lo = wr ? WLO : RLO;
      int hi = wr ? WHI : RHI;
      int ra = $urandom_range(hi + 30, lo - 100);
      fire_sync(wr, 0);
      watch(ra, lo, hi, wr ? "R5 random write" : "R3 random read");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule